// File: doc/BRIEF.md
# Warp Divergence Mask Controller

This block keeps the lane-enable mask of one 32-lane warp while the warp executes conditional branches. Every lane owns one bit of the mask. The branch unit offers a per-lane predicate, a target address, a fall-through address and the address where the two paths meet again. The block compares the predicate with the lanes that are currently enabled. If the enabled lanes all agree, only the program counter changes. If they disagree, the block saves two records on a small stack: one to resume the not-taken lanes and one to restore the combined lanes later. It then runs the taken lanes first. It runs the other lanes once the taken path reaches the meeting address, and it merges all of them when that address comes up again.

The issue stage shows the block the address of the instruction it is issuing, and a branch outcome when that instruction is a branch. The block answers in the same cycle with the address to fetch next. Mask changes take effect on the following cycle, because the mask is registered. Each warp has its own instance, so warps never share stack state.

Top module: `simt_div_ctl`

## Requirements
- R1: After reset, all 32 lanes of `active_mask` are enabled and `overflow` is low.
- R2: In a cycle with no branch and no reconvergence match, `next_pc` equals `cur_pc` plus PC_STEP (default 4), and the mask stays the same.
- R3: A branch whose predicate is 1 on every enabled lane drives `next_pc` to the target and pushes nothing. A later cycle with `cur_pc` at that branch's meeting address then advances by PC_STEP.
- R4: A branch whose predicate is 0 on every enabled lane drives `next_pc` to the fall-through address and leaves the mask unchanged.
- R5: A branch that splits the enabled lanes drives `next_pc` to the target. From the next cycle, the mask equals predicate AND the previous mask.
- R6: When the stack is not empty and `cur_pc` equals the meeting address of the top record, that record is popped. `next_pc` becomes its resume address, and the mask takes its lanes on the next cycle. The first pop after a split resumes the not-taken lanes at the fall-through address. The second pop restores the pre-branch lanes at the meeting address.
- R7: Nested splits unwind last-in first-out. A record whose meeting address does not match `cur_pc` stays on the stack.
- R8: A split that finds fewer than two free records (depth 8) is refused. `next_pc` goes to the target, the mask is unchanged, nothing is pushed, and `overflow` rises on the next cycle and stays high until reset.
- R9: A reconvergence match takes priority over a branch offered in the same cycle, and that branch is dropped.
- R10: Predicate bits of lanes that are disabled have no effect on how a branch is classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | The instruction at `cur_pc` is a resolved branch |
| br_pred | input | 32 | Per-lane branch outcome, 1 = taken |
| br_target | input | 16 | Taken-path address |
| br_fall | input | 16 | Fall-through address |
| br_reconv | input | 16 | Address where both paths meet again |
| cur_pc | input | 16 | Address of the instruction being issued |
| active_mask | output | 32 | Lanes enabled for the instruction at `cur_pc` |
| next_pc | output | 16 | Address to fetch next |
| overflow | output | 1 | Sticky flag: a split was refused for lack of stack space |

## Verification
The checker assumes that the mask stays non-zero, because a split never leaves either path empty. It also assumes that the issue stage presents a meeting address only at true join points. The bench follows these rules by building each scenario from well-formed branch structures: every split names a meeting address beyond both of its paths, and nested splits close inside their enclosing one. The bench presents a branch together with a pending reconvergence match only in the one case that checks priority.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

  // Outcome of classifying one issue cycle
  typedef enum logic [1:0] {
    BK_NONE    = 2'd0,
    BK_UNIFORM = 2'd1,
    BK_SPLIT   = 2'd2,
    BK_REFUSED = 2'd3
  } br_kind_e;

endpackage

// File: rtl/simt_rst_sync.sv
module simt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
  parameter int LANES = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_pair,
  input  logic             pop,
  input  logic [PC_W-1:0]  lo_pc,
  input  logic [LANES-1:0] lo_mask,
  input  logic [PC_W-1:0]  hi_pc,
  input  logic [LANES-1:0] hi_mask,
  input  logic [PC_W-1:0]  wr_rpc,
  output logic [PC_W-1:0]  top_pc,
  output logic [LANES-1:0] top_mask,
  output logic [PC_W-1:0]  top_rpc,
  output logic             empty,
  output logic             room2
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PC_W-1:0]  pc_q   [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [PC_W-1:0]  rpc_q  [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cnt_en;
  logic [AW-1:0]    top_idx;

  // Storage slots: the lower record lands at the current count,
  // the upper record right above it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_lo, wr_hi;
    assign wr_lo = push_pair && (cnt_q == CW'(i));
    assign wr_hi = push_pair && (cnt_q + CW'(1) == CW'(i));

    always_ff @(posedge clk) begin
      if (wr_lo) begin
        pc_q[i]   <= lo_pc;
        mask_q[i] <= lo_mask;
        rpc_q[i]  <= wr_rpc;
      end else if (wr_hi) begin
        pc_q[i]   <= hi_pc;
        mask_q[i] <= hi_mask;
        rpc_q[i]  <= wr_rpc;
      end
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (push_pair) begin
      cnt_d  = cnt_q + CW'(2);
      cnt_en = 1'b1;
    end else if (pop) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign empty    = (cnt_q == '0);
  assign room2    = (int'(cnt_q) + 2 <= DEPTH);
  assign top_idx  = AW'(cnt_q - CW'(1));
  assign top_pc   = pc_q[top_idx];
  assign top_mask = mask_q[top_idx];
  assign top_rpc  = rpc_q[top_idx];

endmodule

// File: rtl/simt_div_eval.sv
module simt_div_eval
  import simt_div_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int PC_W    = 16,
  parameter int PC_STEP = 4
) (
  input  logic             br_valid,
  input  logic [LANES-1:0] br_pred,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fall,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [LANES-1:0] act_mask,
  input  logic [PC_W-1:0]  top_pc,
  input  logic [LANES-1:0] top_mask,
  input  logic [PC_W-1:0]  top_rpc,
  input  logic             empty,
  input  logic             room2,
  output logic             pop,
  output logic             push_pair,
  output logic             ovf_evt,
  output logic             mask_en,
  output logic [LANES-1:0] mask_d,
  output logic [LANES-1:0] nt_mask,
  output logic [PC_W-1:0]  next_pc
);

  br_kind_e         kind;
  logic [LANES-1:0] tk_mask;

  assign tk_mask = br_pred & act_mask;
  assign nt_mask = ~br_pred & act_mask;
  assign pop     = !empty && (cur_pc == top_rpc);

  always_comb begin
    if (pop || !br_valid)                     kind = BK_NONE;
    else if (tk_mask == '0 || nt_mask == '0)  kind = BK_UNIFORM;
    else if (room2)                           kind = BK_SPLIT;
    else                                      kind = BK_REFUSED;
  end

  always_comb begin
    if (pop) next_pc = top_pc;
    else begin
      unique case (kind)
        BK_NONE:    next_pc = cur_pc + PC_W'(PC_STEP);
        BK_UNIFORM: next_pc = (tk_mask != '0) ? br_target : br_fall;
        default:    next_pc = br_target;
      endcase
    end
  end

  assign push_pair = (kind == BK_SPLIT);
  assign ovf_evt   = (kind == BK_REFUSED);
  assign mask_en   = pop || push_pair;
  assign mask_d    = pop ? top_mask : tk_mask;

endmodule

// File: rtl/simt_div_ctl.sv
module simt_div_ctl #(
  parameter int LANES   = 32,
  parameter int PC_W    = 16,
  parameter int DEPTH   = 8,
  parameter int PC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_pred,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fall,
  input  logic [PC_W-1:0]  br_reconv,
  input  logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] active_mask,
  output logic [PC_W-1:0]  next_pc,
  output logic             overflow
);

  logic             rst_sync_n;
  logic             pop, push_pair, ovf_evt, mask_en, empty, room2;
  logic [LANES-1:0] mask_q, mask_d, nt_mask, top_mask;
  logic [PC_W-1:0]  top_pc, top_rpc;
  logic             ovf_q, ovf_d;

  simt_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  simt_div_eval #(.LANES(LANES), .PC_W(PC_W), .PC_STEP(PC_STEP)) i_eval (
    .br_valid  (br_valid),
    .br_pred   (br_pred),
    .br_target (br_target),
    .br_fall   (br_fall),
    .cur_pc    (cur_pc),
    .act_mask  (mask_q),
    .top_pc    (top_pc),
    .top_mask  (top_mask),
    .top_rpc   (top_rpc),
    .empty     (empty),
    .room2     (room2),
    .pop       (pop),
    .push_pair (push_pair),
    .ovf_evt   (ovf_evt),
    .mask_en   (mask_en),
    .mask_d    (mask_d),
    .nt_mask   (nt_mask),
    .next_pc   (next_pc)
  );

  // Lower record restores the merged lanes, upper one resumes the
  // not-taken lanes; both retire at the same meeting address.
  simt_div_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) i_stack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_pair (push_pair),
    .pop       (pop),
    .lo_pc     (br_reconv),
    .lo_mask   (mask_q),
    .hi_pc     (br_fall),
    .hi_mask   (nt_mask),
    .wr_rpc    (br_reconv),
    .top_pc    (top_pc),
    .top_mask  (top_mask),
    .top_rpc   (top_rpc),
    .empty     (empty),
    .room2     (room2)
  );

  assign ovf_d = ovf_q | ovf_evt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovf_q <= 1'b0;
    else             ovf_q <= ovf_d;
  end

  assign active_mask = mask_q;
  assign overflow    = ovf_q;

endmodule

// File: rtl/simt_div_chk.sv
module simt_div_chk #(
  parameter int LANES   = 32,
  parameter int PC_W    = 16,
  parameter int PC_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic [LANES-1:0] br_pred,
  input logic [PC_W-1:0]  br_target,
  input logic [PC_W-1:0]  cur_pc,
  input logic [LANES-1:0] active_mask,
  input logic [PC_W-1:0]  next_pc,
  input logic             overflow,
  input logic             empty,
  input logic [PC_W-1:0]  top_pc,
  input logic [LANES-1:0] top_mask,
  input logic [PC_W-1:0]  top_rpc
);

  logic match, uni;
  assign match = !empty && (cur_pc == top_rpc);
  assign uni   = ((br_pred & active_mask) == active_mask) || ((br_pred & active_mask) == '0);

  AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);  // R5
  AST_QUIET_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !match) |-> next_pc == cur_pc + PC_W'(PC_STEP));  // R2
  AST_QUIET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !match) |=> $stable(active_mask));  // R2
  AST_UNIFORM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !match && uni) |=> $stable(active_mask));  // R3
  AST_SPLIT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !match && !uni) |-> next_pc == br_target);  // R5
  AST_POP_PC: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> next_pc == top_pc);  // R6
  AST_POP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> active_mask == $past(top_mask));  // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);  // R8

endmodule

bind simt_div_ctl simt_div_chk #(.LANES(LANES), .PC_W(PC_W), .PC_STEP(PC_STEP)) i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .br_valid    (br_valid),
  .br_pred     (br_pred),
  .br_target   (br_target),
  .cur_pc      (cur_pc),
  .active_mask (active_mask),
  .next_pc     (next_pc),
  .overflow    (overflow),
  .empty       (empty),
  .top_pc      (top_pc),
  .top_mask    (top_mask),
  .top_rpc     (top_rpc)
);

// File: tb/test_simt_div_ctl.sv
`timescale 1ns/1ps
module test_simt_div_ctl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid;
  logic [31:0] br_pred;
  logic [15:0] br_target, br_fall, br_reconv, cur_pc;
  logic [31:0] active_mask;
  logic [15:0] next_pc;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] q_npc  [$];
  logic [31:0] q_mask [$];
  logic        q_ovf  [$];
  string       q_tag  [$];

  always #4 clk = ~clk;  // 125 MHz

  simt_div_ctl i_simt_div_ctl (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pred(br_pred),
    .br_target(br_target), .br_fall(br_fall), .br_reconv(br_reconv),
    .cur_pc(cur_pc), .active_mask(active_mask), .next_pc(next_pc),
    .overflow(overflow)
  );

  // Driver: one issue cycle plus what the outputs must show in it
  task automatic step(input logic bv, input logic [31:0] pr,
                      input logic [15:0] tg, input logic [15:0] fl,
                      input logic [15:0] rc, input logic [15:0] cu,
                      input logic [15:0] e_npc, input logic [31:0] e_mask,
                      input logic e_ovf, input string tag);
    @(negedge clk);
    br_valid = bv; br_pred = pr; br_target = tg;
    br_fall = fl; br_reconv = rc; cur_pc = cu;
    q_npc.push_back(e_npc); q_mask.push_back(e_mask);
    q_ovf.push_back(e_ovf); q_tag.push_back(tag);
  endtask

  task automatic quiet(input logic [15:0] cu, input logic [15:0] e_npc,
                       input logic [31:0] e_mask, input logic e_ovf, input string tag);
    step(1'b0, 32'h0, 16'h0, 16'h0, 16'h0, cu, e_npc, e_mask, e_ovf, tag);
  endtask

  // Monitor: compares the oldest expectation mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q_npc.size() > 0) begin
        logic [15:0] en; logic [31:0] em; logic eo; string t;
        en = q_npc.pop_front(); em = q_mask.pop_front();
        eo = q_ovf.pop_front(); t = q_tag.pop_front();
        checks++;
        if (next_pc !== en || active_mask !== em || overflow !== eo) begin
          errors++;
          $display("FAIL %s: npc=%h mask=%h ovf=%b expected npc=%h mask=%h ovf=%b",
                   t, next_pc, active_mask, overflow, en, em, eo);
        end
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; br_valid = 1'b0; br_pred = '0; br_target = '0;
    br_fall = '0; br_reconv = '0; cur_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R2 sequential advance
    quiet(16'h0100, 16'h0104, 32'hFFFF_FFFF, 1'b0, "R1 R2 reset");
    // R3 all taken, R4 none taken
    step(1, 32'hFFFF_FFFF, 16'h0200, 16'h0108, 16'h0300, 16'h0104,
         16'h0200, 32'hFFFF_FFFF, 0, "R3 uniform taken");
    step(1, 32'h0, 16'h0220, 16'h0208, 16'h0300, 16'h0200,
         16'h0208, 32'hFFFF_FFFF, 0, "R4 uniform not-taken");
    quiet(16'h0300, 16'h0304, 32'hFFFF_FFFF, 0, "R3 no record pushed");
    // R5 split
    step(1, 32'h0000_FFFF, 16'h0400, 16'h0410, 16'h0500, 16'h03F0,
         16'h0400, 32'hFFFF_FFFF, 0, "R5 split target");
    quiet(16'h0400, 16'h0404, 32'h0000_FFFF, 0, "R5 taken lanes");
    // R10 disabled lanes ignored
    step(1, 32'hFFFF_FFFF, 16'h0480, 16'h0408, 16'h0490, 16'h0404,
         16'h0480, 32'h0000_FFFF, 0, "R10 inactive bits");
    quiet(16'h0480, 16'h0484, 32'h0000_FFFF, 0, "R10 mask kept");
    // R6 two pops
    quiet(16'h0500, 16'h0410, 32'h0000_FFFF, 0, "R6 pop to fall path");
    quiet(16'h0410, 16'h0414, 32'hFFFF_0000, 0, "R6 not-taken lanes");
    quiet(16'h0500, 16'h0500, 32'hFFFF_0000, 0, "R6 pop to merge");
    quiet(16'h0500, 16'h0504, 32'hFFFF_FFFF, 0, "R6 merged lanes");
    // R7 nested
    step(1, 32'h0000_00FF, 16'h0600, 16'h0700, 16'h0800, 16'h0504,
         16'h0600, 32'hFFFF_FFFF, 0, "R7 outer split");
    step(1, 32'h0000_000F, 16'h0640, 16'h0680, 16'h06C0, 16'h0600,
         16'h0640, 32'h0000_00FF, 0, "R7 inner split");
    quiet(16'h06C0, 16'h0680, 32'h0000_000F, 0, "R7 inner pop 1");
    quiet(16'h06C0, 16'h06C0, 32'h0000_00F0, 0, "R7 inner pop 2");
    quiet(16'h06C0, 16'h06C4, 32'h0000_00FF, 0, "R7 outer record kept");
    quiet(16'h0800, 16'h0700, 32'h0000_00FF, 0, "R7 outer pop 1");
    quiet(16'h0800, 16'h0800, 32'hFFFF_FF00, 0, "R7 outer pop 2");
    quiet(16'h0800, 16'h0804, 32'hFFFF_FFFF, 0, "R7 unwound");
    // R9 pop beats branch
    step(1, 32'h0000_0001, 16'h0900, 16'h0910, 16'h0A00, 16'h0804,
         16'h0900, 32'hFFFF_FFFF, 0, "R9 setup split");
    step(1, 32'h0, 16'h0B00, 16'h0B10, 16'h0C00, 16'h0A00,
         16'h0910, 32'h0000_0001, 0, "R9 pop priority");
    quiet(16'h0A00, 16'h0A00, 32'hFFFF_FFFE, 0, "R9 branch dropped");
    quiet(16'h0A00, 16'h0A04, 32'hFFFF_FFFF, 0, "R9 merged");
    // R8 overflow: four splits fill eight records, the fifth is refused
    step(1, 32'h0000_FFFF, 16'h0B00, 16'h0B04, 16'h0C00, 16'h0A04,
         16'h0B00, 32'hFFFF_FFFF, 0, "R8 level 1");
    step(1, 32'h0000_00FF, 16'h0B10, 16'h0B14, 16'h0C40, 16'h0B00,
         16'h0B10, 32'h0000_FFFF, 0, "R8 level 2");
    step(1, 32'h0000_000F, 16'h0B20, 16'h0B24, 16'h0C80, 16'h0B10,
         16'h0B20, 32'h0000_00FF, 0, "R8 level 3");
    step(1, 32'h0000_0003, 16'h0B30, 16'h0B34, 16'h0CC0, 16'h0B20,
         16'h0B30, 32'h0000_000F, 0, "R8 level 4");
    step(1, 32'h0000_0001, 16'h0B40, 16'h0B44, 16'h0D00, 16'h0B30,
         16'h0B40, 32'h0000_0003, 0, "R8 refused split");
    quiet(16'h0B40, 16'h0B44, 32'h0000_0003, 1, "R8 flag raised");
    quiet(16'h0D00, 16'h0D04, 32'h0000_0003, 1, "R8 nothing pushed");
    quiet(16'h0CC0, 16'h0B34, 32'h0000_0003, 1, "R8 level 4 on top");
    quiet(16'h0B34, 16'h0B38, 32'h0000_000C, 1, "R8 flag sticky");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule